// File: doc/BRIEF.md
# Directory Queue Lock Manager

This block sits at the home directory of a shared-memory machine and arbitrates a set of locks without letting waiting nodes spin on a shared variable. Nodes send acquire and release messages. For each lock the directory records whether it is held, which node holds it, and a tail pointer naming the most recent requester. Each node has one successor pointer. A new requester is linked behind the current tail, so the waiters form a chain in arrival order.

When the holder releases a lock, the manager reads the holder's successor pointer and sends a grant to that one node only. It never broadcasts and never invalidates a group of nodes. A release with no successor returns the lock to the free state. Malformed messages are dropped and reported on two error pulses: a release from a node that does not hold the named lock, and an acquire from a node that already holds or waits on some lock.

Acquires and releases arrive on two separate channels, so one of each can be accepted per cycle. Grants leave as a vector with one bit per node. Both the node count and the lock count are parameters, and both should be powers of two.

Top module: `qlk_mgr`

## Requirements
- R1: After reset every output is low, every lock is free and no node is engaged, so the first acquire of any lock is granted.
- R2: An acquire for a free lock from an idle node sets bit n of `gnt_o` (n = node number) for exactly the one cycle after the message, and that node becomes the holder and the tail of the lock.
- R3: An acquire for a held lock produces no grant and links the node behind the current tail; the waiters on a lock are granted in the order their acquires arrived.
- R4: A release by the holder while a successor is linked raises exactly one bit of `gnt_o`, the one for the successor, one cycle later; no other node is informed.
- R5: A release by the holder with no successor produces no grant and frees the lock; a later acquire of that lock is granted at once.
- R6: A release naming a lock that the sending node does not hold changes no state and produces no grant, and `rel_err_o` pulses one cycle later.
- R7: An acquire from a node that already holds or waits on any lock is dropped without a grant or a change to any queue, and `acq_err_o` pulses one cycle later.
- R8: When an acquire and a release are accepted in the same cycle, the release is applied first. A lock freed by that release is granted to the acquirer. A lock handed off by that release gets the acquirer queued behind its tail. A node that releases may acquire another lock in the same cycle. Two `gnt_o` bits may then be set together.
- R9: Queues on different locks are independent: traffic on one lock never changes the holder or the waiter order of another.
- R10: All outputs are registered pulses. In a cycle that follows a cycle with no valid message, `gnt_o`, `acq_err_o` and `rel_err_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acq_vld_i | input | 1 | An acquire message is present |
| acq_node_i | input | $clog2(NODES) | Node sending the acquire |
| acq_lock_i | input | $clog2(LOCKS) | Lock being acquired |
| rel_vld_i | input | 1 | A release message is present |
| rel_node_i | input | $clog2(NODES) | Node sending the release |
| rel_lock_i | input | $clog2(LOCKS) | Lock being released |
| gnt_o | output | NODES | Grant pulses, bit n addressed to node n |
| acq_err_o | output | 1 | Pulse: an acquire was dropped |
| rel_err_o | output | 1 | Pulse: a release was dropped |

## Verification
Two events can fall into the same cycle: a release that hands off or frees a lock, and an acquire that reads that lock's state. The bench drives both channels on the same edge. It covers four cases: a release that frees the lock the acquire targets, a release that hands the lock on while the acquire must join the queue, a node that releases one lock and acquires another, and a handoff together with an immediate grant on a different lock. Each case is judged by the exact grant vector one cycle later and by the grant order of the releases that follow, which shows whether the release-first rule was applied.

// File: rtl/qlk_pkg.sv
package qlk_pkg;

    typedef enum logic [1:0] {
        REL_IDLE,
        REL_PASS,
        REL_FREE,
        REL_BAD
    } rel_act_e;

    typedef enum logic [1:0] {
        ACQ_IDLE,
        ACQ_GRANT,
        ACQ_QUEUE,
        ACQ_BAD
    } acq_act_e;

endpackage

// File: rtl/qlk_lock_table.sv
module qlk_lock_table
    import qlk_pkg::*;
#(
    parameter int NODES = 8,
    parameter int LOCKS = 4,
    parameter int NW    = 3,
    parameter int LW    = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [LW-1:0] rd_a_idx_i,
    output logic          rd_a_busy_o,
    output logic [NW-1:0] rd_a_tail_o,
    input  logic [LW-1:0] rd_r_idx_i,
    output logic          rd_r_busy_o,
    output logic [NW-1:0] rd_r_holder_o,
    input  rel_act_e      rel_act_i,
    input  logic [NW-1:0] rel_new_holder_i,
    input  acq_act_e      acq_act_i,
    input  logic [NW-1:0] acq_node_i
);

    typedef struct packed {
        logic [LOCKS-1:0]         busy;
        logic [LOCKS-1:0][NW-1:0] holder;
        logic [LOCKS-1:0][NW-1:0] tail;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    assign rd_a_busy_o   = tbl_q.busy[rd_a_idx_i];
    assign rd_a_tail_o   = tbl_q.tail[rd_a_idx_i];
    assign rd_r_busy_o   = tbl_q.busy[rd_r_idx_i];
    assign rd_r_holder_o = tbl_q.holder[rd_r_idx_i];

    // Release is written first, acquire second, so a same-lock acquire sees the post-release state.
    always_comb begin
        tbl_d = tbl_q;
        if (rel_act_i == REL_PASS) begin
            tbl_d.holder[rd_r_idx_i] = rel_new_holder_i;
        end else if (rel_act_i == REL_FREE) begin
            tbl_d.busy[rd_r_idx_i] = 1'b0;
        end
        if (acq_act_i == ACQ_GRANT) begin
            tbl_d.busy[rd_a_idx_i]   = 1'b1;
            tbl_d.holder[rd_a_idx_i] = acq_node_i;
            tbl_d.tail[rd_a_idx_i]   = acq_node_i;
        end else if (acq_act_i == ACQ_QUEUE) begin
            tbl_d.tail[rd_a_idx_i] = acq_node_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

endmodule

// File: rtl/qlk_link_store.sv
module qlk_link_store
    import qlk_pkg::*;
#(
    parameter int NODES = 8,
    parameter int NW    = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [NW-1:0] rd_a_node_i,
    output logic          rd_a_eng_o,
    input  logic [NW-1:0] rd_r_node_i,
    output logic          rd_r_nvld_o,
    output logic [NW-1:0] rd_r_nxt_o,
    input  rel_act_e      rel_act_i,
    input  acq_act_e      acq_act_i,
    input  logic [NW-1:0] acq_tail_i
);

    typedef struct packed {
        logic [NODES-1:0]         eng;
        logic [NODES-1:0]         nvld;
        logic [NODES-1:0][NW-1:0] nxt;
    } lnk_t;

    lnk_t lnk_d, lnk_q;

    assign rd_a_eng_o  = lnk_q.eng[rd_a_node_i];
    assign rd_r_nvld_o = lnk_q.nvld[rd_r_node_i];
    assign rd_r_nxt_o  = lnk_q.nxt[rd_r_node_i];

    always_comb begin
        lnk_d = lnk_q;
        if (rel_act_i == REL_PASS || rel_act_i == REL_FREE) begin
            lnk_d.eng[rd_r_node_i]  = 1'b0;
            lnk_d.nvld[rd_r_node_i] = 1'b0;
        end
        if (acq_act_i == ACQ_GRANT || acq_act_i == ACQ_QUEUE) begin
            lnk_d.eng[rd_a_node_i] = 1'b1;
        end
        if (acq_act_i == ACQ_QUEUE) begin
            lnk_d.nxt[acq_tail_i]  = rd_a_node_i;
            lnk_d.nvld[acq_tail_i] = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lnk_q <= '0;
        end else begin
            lnk_q <= lnk_d;
        end
    end

endmodule

// File: rtl/qlk_ctrl.sv
module qlk_ctrl
    import qlk_pkg::*;
#(
    parameter int NODES = 8,
    parameter int NW    = 3,
    parameter int LW    = 2
) (
    input  logic             acq_vld_i,
    input  logic [NW-1:0]    acq_node_i,
    input  logic [LW-1:0]    acq_lock_i,
    input  logic             rel_vld_i,
    input  logic [NW-1:0]    rel_node_i,
    input  logic [LW-1:0]    rel_lock_i,
    input  logic             a_busy_i,
    input  logic             r_busy_i,
    input  logic [NW-1:0]    r_holder_i,
    input  logic             a_eng_i,
    input  logic             r_nvld_i,
    input  logic [NW-1:0]    r_nxt_i,
    output rel_act_e         rel_act_o,
    output acq_act_e         acq_act_o,
    output logic [NODES-1:0] gnt_o,
    output logic             acq_err_o,
    output logic             rel_err_o
);

    logic rel_hit;
    logic rel_done;
    logic eff_busy;
    logic eff_eng;

    always_comb begin
        rel_hit = rel_vld_i && r_busy_i && (r_holder_i == rel_node_i);
        if (!rel_vld_i) begin
            rel_act_o = REL_IDLE;
        end else if (!rel_hit) begin
            rel_act_o = REL_BAD;
        end else if (r_nvld_i) begin
            rel_act_o = REL_PASS;
        end else begin
            rel_act_o = REL_FREE;
        end
        rel_done = (rel_act_o == REL_PASS) || (rel_act_o == REL_FREE);

        // The acquire sees the state the release leaves behind.
        eff_busy = a_busy_i && !((rel_act_o == REL_FREE) && (rel_lock_i == acq_lock_i));
        eff_eng  = a_eng_i && !(rel_done && (rel_node_i == acq_node_i));

        if (!acq_vld_i) begin
            acq_act_o = ACQ_IDLE;
        end else if (eff_eng) begin
            acq_act_o = ACQ_BAD;
        end else if (eff_busy) begin
            acq_act_o = ACQ_QUEUE;
        end else begin
            acq_act_o = ACQ_GRANT;
        end

        gnt_o = '0;
        if (rel_act_o == REL_PASS) begin
            gnt_o[r_nxt_i] = 1'b1;
        end
        if (acq_act_o == ACQ_GRANT) begin
            gnt_o[acq_node_i] = 1'b1;
        end
        acq_err_o = (acq_act_o == ACQ_BAD);
        rel_err_o = (rel_act_o == REL_BAD);
    end

endmodule

// File: rtl/qlk_mgr.sv
module qlk_mgr
    import qlk_pkg::*;
#(
    parameter int NODES = 8,
    parameter int LOCKS = 4,
    localparam int NW   = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int LW   = (LOCKS > 1) ? $clog2(LOCKS) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             acq_vld_i,
    input  logic [NW-1:0]    acq_node_i,
    input  logic [LW-1:0]    acq_lock_i,
    input  logic             rel_vld_i,
    input  logic [NW-1:0]    rel_node_i,
    input  logic [LW-1:0]    rel_lock_i,
    output logic [NODES-1:0] gnt_o,
    output logic             acq_err_o,
    output logic             rel_err_o
);

    typedef struct packed {
        logic [NODES-1:0] gnt;
        logic             aerr;
        logic             rerr;
    } out_t;

    out_t out_d, out_q;

    rel_act_e         rel_act;
    acq_act_e         acq_act;
    logic             a_busy, r_busy, a_eng, r_nvld;
    logic [NW-1:0]    a_tail, r_holder, r_nxt;
    logic [NODES-1:0] gnt_c;
    logic             aerr_c, rerr_c;

    qlk_lock_table #(.NODES(NODES), .LOCKS(LOCKS), .NW(NW), .LW(LW)) u_tbl (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .rd_a_idx_i      (acq_lock_i),
        .rd_a_busy_o     (a_busy),
        .rd_a_tail_o     (a_tail),
        .rd_r_idx_i      (rel_lock_i),
        .rd_r_busy_o     (r_busy),
        .rd_r_holder_o   (r_holder),
        .rel_act_i       (rel_act),
        .rel_new_holder_i(r_nxt),
        .acq_act_i       (acq_act),
        .acq_node_i      (acq_node_i)
    );

    qlk_link_store #(.NODES(NODES), .NW(NW)) u_lnk (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rd_a_node_i(acq_node_i),
        .rd_a_eng_o (a_eng),
        .rd_r_node_i(rel_node_i),
        .rd_r_nvld_o(r_nvld),
        .rd_r_nxt_o (r_nxt),
        .rel_act_i  (rel_act),
        .acq_act_i  (acq_act),
        .acq_tail_i (a_tail)
    );

    qlk_ctrl #(.NODES(NODES), .NW(NW), .LW(LW)) u_ctrl (
        .acq_vld_i (acq_vld_i),
        .acq_node_i(acq_node_i),
        .acq_lock_i(acq_lock_i),
        .rel_vld_i (rel_vld_i),
        .rel_node_i(rel_node_i),
        .rel_lock_i(rel_lock_i),
        .a_busy_i  (a_busy),
        .r_busy_i  (r_busy),
        .r_holder_i(r_holder),
        .a_eng_i   (a_eng),
        .r_nvld_i  (r_nvld),
        .r_nxt_i   (r_nxt),
        .rel_act_o (rel_act),
        .acq_act_o (acq_act),
        .gnt_o     (gnt_c),
        .acq_err_o (aerr_c),
        .rel_err_o (rerr_c)
    );

    always_comb begin
        out_d      = out_q;
        out_d.gnt  = gnt_c;
        out_d.aerr = aerr_c;
        out_d.rerr = rerr_c;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign gnt_o     = out_q.gnt;
    assign acq_err_o = out_q.aerr;
    assign rel_err_o = out_q.rerr;

endmodule

// File: rtl/qlk_mgr_chk.sv
module qlk_mgr_chk #(
    parameter int NODES = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             acq_vld_i,
    input logic             rel_vld_i,
    input logic [NODES-1:0] gnt_o,
    input logic             acq_err_o,
    input logic             rel_err_o
);

    logic armed_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    // R4
    rel_single_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
        $past(rel_vld_i && !acq_vld_i) |-> ($countones(gnt_o) <= 1));

    // R6
    rel_err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
        (rel_err_o && !$past(acq_vld_i)) |-> (gnt_o == '0));

    // R6
    rel_err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
        rel_err_o |-> $past(rel_vld_i));

    // R7
    acq_err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
        (acq_err_o && !$past(rel_vld_i)) |-> (gnt_o == '0));

    // R8
    grant_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
        $countones(gnt_o) <= 2);

    // R10
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
        !$past(acq_vld_i || rel_vld_i) |-> (gnt_o == '0 && !acq_err_o && !rel_err_o));

endmodule

bind qlk_mgr qlk_mgr_chk #(.NODES(NODES)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acq_vld_i(acq_vld_i),
    .rel_vld_i(rel_vld_i),
    .gnt_o    (gnt_o),
    .acq_err_o(acq_err_o),
    .rel_err_o(rel_err_o)
);

// File: tb/qlk_mgr_tb_top.sv
`timescale 1ns/1ps
module qlk_mgr_tb_top;

    localparam int NODES = 8;
    localparam int LOCKS = 4;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       acq_vld_i = 1'b0;
    logic [2:0] acq_node_i = '0;
    logic [1:0] acq_lock_i = '0;
    logic       rel_vld_i = 1'b0;
    logic [2:0] rel_node_i = '0;
    logic [1:0] rel_lock_i = '0;
    logic [7:0] gnt_o;
    logic       acq_err_o, rel_err_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk_i = ~clk_i;

    qlk_mgr #(.NODES(NODES), .LOCKS(LOCKS)) dut_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .acq_vld_i (acq_vld_i),
        .acq_node_i(acq_node_i),
        .acq_lock_i(acq_lock_i),
        .rel_vld_i (rel_vld_i),
        .rel_node_i(rel_node_i),
        .rel_lock_i(rel_lock_i),
        .gnt_o     (gnt_o),
        .acq_err_o (acq_err_o),
        .rel_err_o (rel_err_o)
    );

    always @(posedge clk_i) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors = errors + 1;
            $display("FAIL watchdog expired act=%0d exp=<20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle of messages, then check the registered outputs one cycle later.
    task automatic step(input bit av, input int an, input int al,
                        input bit rv, input int rn, input int rl,
                        input int eg, input bit ea, input bit er, input string tag);
        @(negedge clk_i);
        acq_vld_i  = av;
        acq_node_i = 3'(an);
        acq_lock_i = 2'(al);
        rel_vld_i  = rv;
        rel_node_i = 3'(rn);
        rel_lock_i = 2'(rl);
        @(negedge clk_i);
        acq_vld_i = 1'b0;
        rel_vld_i = 1'b0;
        chk(tag, "gnt", int'(gnt_o), eg);
        chk(tag, "acq_err", int'(acq_err_o), int'(ea));
        chk(tag, "rel_err", int'(rel_err_o), int'(er));
    endtask

    task automatic acq(input int n, input int l, input int eg, input bit ea, input string tag);
        step(1'b1, n, l, 1'b0, 0, 0, eg, ea, 1'b0, tag);
    endtask

    task automatic rel(input int n, input int l, input int eg, input bit er, input string tag);
        step(1'b0, 0, 0, 1'b1, n, l, eg, 1'b0, er, tag);
    endtask

    task automatic t_reset;
        chk("R1", "gnt after reset", int'(gnt_o), 0);
        chk("R1", "errs after reset", int'({acq_err_o, rel_err_o}), 0);
        acq(0, 0, 8'h01, 1'b0, "R1 R2 first acquire");
        rel(0, 0, 8'h00, 1'b0, "R5 sole holder release");
        acq(5, 0, 8'h20, 1'b0, "R5 reacquire freed lock");
        rel(5, 0, 8'h00, 1'b0, "R5 cleanup");
        @(negedge clk_i);
        chk("R10", "idle outputs", int'({gnt_o, acq_err_o, rel_err_o}), 0);
    endtask

    task automatic t_queue;
        acq(1, 1, 8'h02, 1'b0, "R2 grant n1");
        acq(2, 1, 8'h00, 1'b0, "R3 queue n2");
        acq(3, 1, 8'h00, 1'b0, "R3 queue n3");
        acq(4, 1, 8'h00, 1'b0, "R3 queue n4");
        rel(1, 1, 8'h04, 1'b0, "R4 handoff to n2");
        rel(2, 1, 8'h08, 1'b0, "R4 R3 handoff to n3");
        rel(3, 1, 8'h10, 1'b0, "R4 R3 handoff to n4");
        rel(4, 1, 8'h00, 1'b0, "R5 last release");
        acq(6, 1, 8'h40, 1'b0, "R5 lock free again");
        rel(6, 1, 8'h00, 1'b0, "R5 cleanup");
    endtask

    task automatic t_bad_release;
        acq(0, 2, 8'h01, 1'b0, "R6 setup holder");
        acq(1, 2, 8'h00, 1'b0, "R6 setup waiter");
        rel(1, 2, 8'h00, 1'b1, "R6 waiter releases");
        rel(7, 2, 8'h00, 1'b1, "R6 idle node releases");
        rel(0, 3, 8'h00, 1'b1, "R6 wrong lock");
        rel(0, 2, 8'h02, 1'b0, "R6 queue intact");
        rel(1, 2, 8'h00, 1'b0, "R6 cleanup");
    endtask

    task automatic t_dup_acquire;
        acq(2, 0, 8'h04, 1'b0, "R7 setup");
        acq(2, 3, 8'h00, 1'b1, "R7 holder acquires again");
        acq(3, 3, 8'h08, 1'b0, "R7 dropped acquire left lock free");
        acq(3, 0, 8'h00, 1'b1, "R7 holder of other lock");
        acq(4, 0, 8'h00, 1'b0, "R7 queue n4");
        acq(4, 0, 8'h00, 1'b1, "R7 waiter acquires again");
        rel(2, 0, 8'h10, 1'b0, "R7 single link for n4");
        rel(4, 0, 8'h00, 1'b0, "R7 no duplicate entry");
        rel(3, 3, 8'h00, 1'b0, "R7 cleanup");
        acq(5, 0, 8'h20, 1'b0, "R7 lock free after chain");
        rel(5, 0, 8'h00, 1'b0, "R7 cleanup 2");
    endtask

    task automatic t_same_cycle;
        acq(0, 1, 8'h01, 1'b0, "R8 a setup");
        step(1'b1, 1, 1, 1'b1, 0, 1, 8'h02, 1'b0, 1'b0, "R8 free then grant");
        rel(1, 1, 8'h00, 1'b0, "R8 a cleanup");

        acq(2, 2, 8'h04, 1'b0, "R8 b setup");
        acq(3, 2, 8'h00, 1'b0, "R8 b queue");
        step(1'b1, 4, 2, 1'b1, 2, 2, 8'h08, 1'b0, 1'b0, "R8 handoff plus queue");
        rel(3, 2, 8'h10, 1'b0, "R8 acquirer behind tail");
        rel(4, 2, 8'h00, 1'b0, "R8 b cleanup");

        acq(5, 3, 8'h20, 1'b0, "R8 c setup");
        step(1'b1, 5, 0, 1'b1, 5, 3, 8'h20, 1'b0, 1'b0, "R8 release and reacquire");
        rel(5, 0, 8'h00, 1'b0, "R8 c cleanup");
        acq(6, 3, 8'h40, 1'b0, "R8 c first lock freed");
        rel(6, 3, 8'h00, 1'b0, "R8 c cleanup 2");

        acq(0, 1, 8'h01, 1'b0, "R8 d setup");
        acq(1, 1, 8'h00, 1'b0, "R8 d queue");
        step(1'b1, 2, 2, 1'b1, 0, 1, 8'h06, 1'b0, 1'b0, "R8 two grants");
        rel(1, 1, 8'h00, 1'b0, "R8 d cleanup");
        rel(2, 2, 8'h00, 1'b0, "R8 d cleanup 2");
    endtask

    task automatic t_independent;
        acq(0, 0, 8'h01, 1'b0, "R9 hold L0");
        acq(1, 1, 8'h02, 1'b0, "R9 hold L1");
        acq(2, 0, 8'h00, 1'b0, "R9 wait L0");
        acq(3, 1, 8'h00, 1'b0, "R9 wait L1");
        rel(1, 1, 8'h08, 1'b0, "R9 L1 handoff only");
        rel(0, 0, 8'h04, 1'b0, "R9 L0 handoff only");
        rel(3, 1, 8'h00, 1'b0, "R9 cleanup");
        rel(2, 0, 8'h00, 1'b0, "R9 cleanup 2");
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_queue();
        t_bad_release();
        t_dup_acquire();
        t_same_cycle();
        t_independent();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule